// File: doc/BRIEF.md
# Power-Down and Wake-Up Sequencer

This block sits beside a small 8-bit controller core and runs its hardware power-down mode. A low level on the active-low control pin stops the core clock and puts the core's I/O pads into high impedance. The core keeps its internal state while it is stopped. When the control pin goes high again, the sequencer samples the active-low reset and interrupt pins and chooses one of three outcomes. It can hold the core in reset and then start it from address 0. It can raise an external interrupt that vectors to address 3. Or it can let the core carry on with the next instruction.

All three pins are asynchronous to the clock and pass through a two-flop synchroniser. After power returns, a stabilisation counter must expire before the core clock is enabled again. The interrupt outcome then has to be confirmed: the interrupt pin must stay low while the running core issues a set number of ALE strobes. Two core status flags decide whether a confirmed interrupt wake raises an interrupt or only resumes. One flag says interrupts are enabled. The other says the core is already inside a service routine. The outcome is reported as a one-cycle wake code.

Top module: `pwr_wake_seq`

## Requirements
- R1: After `rst_ni` is released and while all pins stay high, `clk_en_o`=1, `pad_float_o`=0, `core_rst_o`=0, `irq_o`=0 and `wake_code_o`=00.
- R2: When `pd_ni` is driven low, `clk_en_o` falls and `pad_float_o` rises on the third rising clock edge after the change, and not earlier.
- R3: After `pd_ni` rises, `clk_en_o` stays low for `STAB_CYCLES` cycles after the synchronised rise. On a plain resume, `clk_en_o` returns on the (`STAB_CYCLES`+3)th rising edge after the pin change, and `pad_float_o` falls at the same edge.
- R4: If `reset_ni` is low when the wake is decided, then after stabilisation `clk_en_o`=1 and `core_rst_o`=1 for as long as the pin stays low. `core_rst_o` falls on the third rising edge after the pin rises, and `wake_code_o`=01 in that same cycle.
- R5: If both `reset_ni` and `int_ni` are low at the wake decision, the reset outcome is taken (code 01) and no interrupt is raised.
- R6: If interrupts are enabled, the core is not in a service routine, and `int_ni` stays low from the wake decision through two `ale_i` strobes, then `irq_o` pulses for one cycle together with `wake_code_o`=10. Neither output changes before the second strobe.
- R7: The same wake while `in_isr_i`=1 produces `wake_code_o`=11 and no `irq_o` pulse.
- R8: The same wake while `int_en_i`=0 produces `wake_code_o`=11 and no `irq_o` pulse.
- R9: If `int_ni` rises before the second ALE strobe, the ALE count is dropped and the wake ends as a resume: code 11, no `irq_o`.
- R10: If both `reset_ni` and `int_ni` are high at the wake decision, the wake ends as a resume (code 11) with no core reset and no interrupt.
- R11: `wake_code_o` is 00 except for exactly one cycle per completed wake, in which it holds the outcome: 01 reset, 10 interrupt vector, 11 resume.
- R12: If `pd_ni` drops again during stabilisation, the sequencer returns to power-down with the clock off and pads floating, and it reports no wake code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Free-running clock |
| rst_ni | input | 1 | Asynchronous active-low block reset |
| pd_ni | input | 1 | Power-down control pin, low = power down (asynchronous) |
| reset_ni | input | 1 | External reset pin, active low (asynchronous) |
| int_ni | input | 1 | External interrupt pin, active low (asynchronous) |
| ale_i | input | 1 | One-cycle strobe per ALE pulse from the core |
| int_en_i | input | 1 | Core flag: external interrupts enabled |
| in_isr_i | input | 1 | Core flag: core is inside an interrupt routine |
| clk_en_o | output | 1 | Core clock enable |
| pad_float_o | output | 1 | Put core I/O pads in high impedance |
| core_rst_o | output | 1 | Core reset, active high |
| irq_o | output | 1 | One-cycle external interrupt request |
| wake_code_o | output | 2 | Wake outcome, valid for one cycle |

## Verification
A wrong captured wake path shows up one stabilisation period after the control pin rises. At that point the wrong one of `core_rst_o`, the ALE wait, or an immediate code 11 appears. A stabilisation counter that is off by one moves the `clk_en_o` rising edge by that many cycles, so the bench times this edge exactly. An ALE count that is wrong or never cleared shows in the first cycle after a strobe: the interrupt outcome arrives one strobe early or late, or an aborted interrupt wake raises `irq_o`.

// File: rtl/pws_pkg.sv
package pws_pkg;
  typedef enum logic [2:0] {
    ST_RUN  = 3'd0,
    ST_DOWN = 3'd1,
    ST_STAB = 3'd2,
    ST_RST  = 3'd3,
    ST_INTW = 3'd4
  } state_t;

  typedef enum logic [1:0] {
    WK_NONE   = 2'b00,
    WK_RST    = 2'b01,
    WK_IRQ    = 2'b10,
    WK_RESUME = 2'b11
  } wake_t;

  typedef enum logic [1:0] {
    P_RESUME = 2'd0,
    P_RST    = 2'd1,
    P_INT    = 2'd2
  } path_t;
endpackage

// File: rtl/pws_sync.sv
module pws_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  // pins are active low: reset to the inactive level
  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    logic [STAGES-1:0] chain_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain_q <= '1;
      else         chain_q <= {chain_q[STAGES-2:0], d_i[b]};
    end
    assign q_o[b] = chain_q[STAGES-1];
  end
endmodule

// File: rtl/pws_stab_cnt.sv
module pws_stab_cnt #(
  parameter int STAB_CYCLES = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  output logic done_o
);
  localparam int CW = $clog2(STAB_CYCLES + 1);
  localparam logic [CW-1:0] LOAD_VAL = CW'(STAB_CYCLES - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (load_i)        cnt_q <= LOAD_VAL;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign done_o = (cnt_q == '0);

  // R3
  stab_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i && (STAB_CYCLES > 1) |=> !done_o);
endmodule

// File: rtl/pws_fsm.sv
module pws_fsm
  import pws_pkg::*;
#(
  parameter int ALE_MIN = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       pd_s_i,
  input  logic       rst_s_i,
  input  logic       int_s_i,
  input  logic       ale_i,
  input  logic       int_en_i,
  input  logic       in_isr_i,
  input  logic       stab_done_i,
  output logic       stab_load_o,
  output logic       clk_en_o,
  output logic       pad_float_o,
  output logic       core_rst_o,
  output logic       irq_o,
  output logic [1:0] wake_code_o
);
  localparam int AW = $clog2(ALE_MIN + 1);
  localparam logic [AW-1:0] ALE_LAST = AW'(ALE_MIN - 1);

  state_t        state_q, state_d;
  path_t         path_q, path_d;
  logic [AW-1:0] ale_cnt_q, ale_cnt_d;
  wake_t         code_q, code_d;
  logic          irq_q, irq_d;

  always_comb begin
    state_d     = state_q;
    path_d      = path_q;
    ale_cnt_d   = ale_cnt_q;
    code_d      = WK_NONE;
    irq_d       = 1'b0;
    stab_load_o = 1'b0;
    unique case (state_q)
      ST_RUN: if (!pd_s_i) state_d = ST_DOWN;
      ST_DOWN: if (pd_s_i) begin
        state_d     = ST_STAB;
        stab_load_o = 1'b1;
        // reset outranks interrupt
        if (!rst_s_i)      path_d = P_RST;
        else if (!int_s_i) path_d = P_INT;
        else               path_d = P_RESUME;
      end
      ST_STAB: begin
        if (!pd_s_i) state_d = ST_DOWN;
        else if (stab_done_i) begin
          unique case (path_q)
            P_RST: state_d = ST_RST;
            P_INT: begin
              state_d   = ST_INTW;
              ale_cnt_d = '0;
            end
            default: begin
              state_d = ST_RUN;
              code_d  = WK_RESUME;
            end
          endcase
        end
      end
      ST_RST: begin
        if (!pd_s_i) state_d = ST_DOWN;
        else if (rst_s_i) begin
          state_d = ST_RUN;
          code_d  = WK_RST;
        end
      end
      ST_INTW: begin
        if (!pd_s_i) state_d = ST_DOWN;
        else if (int_s_i) begin
          // pin released early: drop the count, plain resume
          state_d = ST_RUN;
          code_d  = WK_RESUME;
        end else if (ale_i) begin
          if (ale_cnt_q == ALE_LAST) begin
            state_d = ST_RUN;
            if (int_en_i && !in_isr_i) begin
              code_d = WK_IRQ;
              irq_d  = 1'b1;
            end else begin
              code_d = WK_RESUME;
            end
          end else begin
            ale_cnt_d = ale_cnt_q + 1'b1;
          end
        end
      end
      default: state_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_RUN;
      path_q    <= P_RESUME;
      ale_cnt_q <= '0;
      code_q    <= WK_NONE;
      irq_q     <= 1'b0;
    end else begin
      state_q   <= state_d;
      path_q    <= path_d;
      ale_cnt_q <= ale_cnt_d;
      code_q    <= code_d;
      irq_q     <= irq_d;
    end
  end

  assign clk_en_o    = (state_q == ST_RUN) || (state_q == ST_RST) || (state_q == ST_INTW);
  assign pad_float_o = (state_q == ST_DOWN) || (state_q == ST_STAB);
  assign core_rst_o  = (state_q == ST_RST);
  assign irq_o       = irq_q;
  assign wake_code_o = code_q;

  // R11
  code_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wake_code_o != WK_NONE) |=> (wake_code_o == WK_NONE));
  // R6
  irq_code_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (wake_code_o == WK_IRQ));
  // R7
  irq_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> $past(int_en_i && !in_isr_i && ale_i && !int_s_i));
  // R4
  rst_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(core_rst_o) |-> (wake_code_o == WK_RST) || pad_float_o);
  // R2
  down_entry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pad_float_o) |-> $past(!pd_s_i));
endmodule

// File: rtl/pwr_wake_seq.sv
module pwr_wake_seq #(
  parameter int STAB_CYCLES = 16,
  parameter int ALE_MIN     = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       pd_ni,
  input  logic       reset_ni,
  input  logic       int_ni,
  input  logic       ale_i,
  input  logic       int_en_i,
  input  logic       in_isr_i,
  output logic       clk_en_o,
  output logic       pad_float_o,
  output logic       core_rst_o,
  output logic       irq_o,
  output logic [1:0] wake_code_o
);
  logic [2:0] pins_s;
  logic       stab_load, stab_done;

  pws_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) sync_i (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({int_ni, reset_ni, pd_ni}),
    .q_o   (pins_s)
  );

  pws_stab_cnt #(.STAB_CYCLES(STAB_CYCLES)) stab_i (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .load_i(stab_load),
    .done_o(stab_done)
  );

  pws_fsm #(.ALE_MIN(ALE_MIN)) fsm_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .pd_s_i     (pins_s[0]),
    .rst_s_i    (pins_s[1]),
    .int_s_i    (pins_s[2]),
    .ale_i      (ale_i),
    .int_en_i   (int_en_i),
    .in_isr_i   (in_isr_i),
    .stab_done_i(stab_done),
    .stab_load_o(stab_load),
    .clk_en_o   (clk_en_o),
    .pad_float_o(pad_float_o),
    .core_rst_o (core_rst_o),
    .irq_o      (irq_o),
    .wake_code_o(wake_code_o)
  );

  // R3
  stab_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(clk_en_o) |-> $past(stab_done));
endmodule

// File: tb/pwr_wake_seq_tb_top.sv
module pwr_wake_seq_tb_top;
  localparam int STAB = 16;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic pd_ni = 1'b1, reset_ni = 1'b1, int_ni = 1'b1, ale_i = 1'b0;
  logic int_en_i = 1'b0, in_isr_i = 1'b0;
  logic clk_en_o, pad_float_o, core_rst_o, irq_o;
  logic [1:0] wake_code_o;

  int total = 0, bad = 0;
  int code_cycles = 0, irq_cnt = 0, last_code = 0;

  always #2 clk_i = ~clk_i;

  pwr_wake_seq #(.STAB_CYCLES(STAB)) dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .pd_ni(pd_ni), .reset_ni(reset_ni),
    .int_ni(int_ni), .ale_i(ale_i), .int_en_i(int_en_i), .in_isr_i(in_isr_i),
    .clk_en_o(clk_en_o), .pad_float_o(pad_float_o), .core_rst_o(core_rst_o),
    .irq_o(irq_o), .wake_code_o(wake_code_o)
  );

  always @(negedge clk_i) begin
    if (rst_ni) begin
      if (wake_code_o != 2'b00) begin
        code_cycles++;
        last_code = int'(wake_code_o);
      end
      if (irq_o) irq_cnt++;
    end
  end

  task automatic chk_eq(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic clr_mon();
    code_cycles = 0;
    irq_cnt     = 0;
    last_code   = 0;
  endtask

  task automatic wait_clk_en(output int n);
    n = 0;
    while (!clk_en_o && n < 200) begin
      @(negedge clk_i);
      n++;
    end
  endtask

  task automatic check_outcome(input string req, input int code, input int irqs);
    repeat (4) @(negedge clk_i);
    chk_eq({req, " code"}, last_code, code);
    chk_eq({req, " code width (R11)"}, code_cycles, 1);
    chk_eq({req, " irq count"}, irq_cnt, irqs);
  endtask

  task automatic enter_pd();
    @(negedge clk_i);
    pd_ni = 1'b0;
    repeat (2) @(negedge clk_i);
    chk_eq("R2 clk_en before 3rd edge", int'(clk_en_o), 1);
    @(negedge clk_i);
    chk_eq("R2 clk_en", int'(clk_en_o), 0);
    chk_eq("R2 pad_float", int'(pad_float_o), 1);
    repeat (3) @(negedge clk_i);
  endtask

  task automatic t_resume();
    int n;
    enter_pd();
    clr_mon();
    @(negedge clk_i);
    pd_ni = 1'b1;
    wait_clk_en(n);
    chk_eq("R3 stab length", n, STAB + 3);
    chk_eq("R3 pad_float off", int'(pad_float_o), 0);
    chk_eq("R10 resume code now", int'(wake_code_o), 3);
    chk_eq("R10 no core reset", int'(core_rst_o), 0);
    check_outcome("R10", 3, 0);
  endtask

  task automatic t_reset(input logic int_pin, input string req);
    int n;
    enter_pd();
    reset_ni = 1'b0;
    int_ni   = int_pin;
    int_en_i = 1'b1;
    repeat (3) @(negedge clk_i);
    clr_mon();
    pd_ni = 1'b1;
    wait_clk_en(n);
    chk_eq({req, " core_rst held"}, int'(core_rst_o), 1);
    repeat (5) @(negedge clk_i);
    chk_eq({req, " core_rst still held"}, int'(core_rst_o), 1);
    chk_eq({req, " no code while held"}, code_cycles, 0);
    reset_ni = 1'b1;
    repeat (2) @(negedge clk_i);
    chk_eq("R4 core_rst before 3rd edge", int'(core_rst_o), 1);
    @(negedge clk_i);
    chk_eq("R4 core_rst released", int'(core_rst_o), 0);
    chk_eq("R4 code 01", int'(wake_code_o), 1);
    int_ni = 1'b1;
    check_outcome(req, 1, 0);
    int_en_i = 1'b0;
  endtask

  task automatic t_int(input logic en, input logic isr, input logic short_pin,
                       input string req, input int exp_code, input int exp_irq);
    int n;
    enter_pd();
    int_ni   = 1'b0;
    int_en_i = en;
    in_isr_i = isr;
    repeat (3) @(negedge clk_i);
    clr_mon();
    pd_ni = 1'b1;
    wait_clk_en(n);
    chk_eq({req, " clock on for ALE wait"}, int'(clk_en_o), 1);
    repeat (2) @(negedge clk_i);
    ale_i = 1'b1;
    @(negedge clk_i);
    ale_i = 1'b0;
    repeat (3) @(negedge clk_i);
    chk_eq({req, " nothing after one ALE"}, code_cycles + irq_cnt, 0);
    if (short_pin) begin
      int_ni = 1'b1;
      repeat (4) @(negedge clk_i);
      ale_i = 1'b1;
      @(negedge clk_i);
      ale_i = 1'b0;
    end else begin
      ale_i = 1'b1;
      @(negedge clk_i);
      ale_i = 1'b0;
      chk_eq({req, " code at 2nd ALE"}, int'(wake_code_o), exp_code);
      repeat (2) @(negedge clk_i);
      int_ni = 1'b1;
    end
    check_outcome(req, exp_code, exp_irq);
    int_en_i = 1'b0;
    in_isr_i = 1'b0;
  endtask

  task automatic t_redrop();
    enter_pd();
    clr_mon();
    pd_ni = 1'b1;
    repeat (8) @(negedge clk_i);
    pd_ni = 1'b0;
    repeat (30) @(negedge clk_i);
    chk_eq("R12 clk_en off", int'(clk_en_o), 0);
    chk_eq("R12 pads float", int'(pad_float_o), 1);
    chk_eq("R12 no code", code_cycles, 0);
    pd_ni = 1'b1;
    repeat (STAB + 8) @(negedge clk_i);
    chk_eq("R12 later resume code", last_code, 3);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    repeat (4) @(negedge clk_i);
    // R1
    chk_eq("R1 clk_en", int'(clk_en_o), 1);
    chk_eq("R1 pad_float", int'(pad_float_o), 0);
    chk_eq("R1 core_rst", int'(core_rst_o), 0);
    chk_eq("R1 irq", int'(irq_o), 0);
    chk_eq("R1 code", int'(wake_code_o), 0);
    t_resume();
    t_reset(1'b1, "R4");
    t_reset(1'b0, "R5");
    t_int(1'b1, 1'b0, 1'b0, "R6", 2, 1);
    t_int(1'b1, 1'b1, 1'b0, "R7", 3, 0);
    t_int(1'b0, 1'b0, 1'b0, "R8", 3, 0);
    t_int(1'b1, 1'b0, 1'b1, "R9", 3, 0);
    t_redrop();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #400000;
    bad++;
    $display("FAIL watchdog act=0 exp=1");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule